// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block holds a small table of VLAN entries. Each entry pairs a 12-bit VLAN identifier with a port membership mask and an optional priority override. Software never writes the table directly. It first loads a data register with a membership mask and a valid flag. It then writes a command register holding an operation code, a VLAN ID or port number, and a start bit. The engine carries out the command over several cycles, walking the table one entry per cycle, and clears the start bit when it finishes.

Forwarding logic reads the table through a separate lookup port. It presents a VLAN ID and receives, in the same cycle, a hit flag, the membership mask and the priority settings. While a command runs, further register writes are dropped, so a command in flight always sees the data it was started with. A load that needs a new slot when none is free raises a table-full flag and leaves the table unchanged.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the start bit and the full flag are 0, both registers read as zero, and every lookup misses with a zero mask and zero priority outputs.
- R2: A write to the command register (reg_sel=0) with bit 3 set starts the operation in bits [2:0] and sets bit 3 at the next clock. Bit 3 clears by itself within ENTRIES+1 cycles. Codes 0 and 5 to 7 change nothing.
- R3: Operation code 1 (flush) leaves every entry invalid.
- R4: Operation code 2 (load) stores an entry with the VLAN ID from command bits [27:16], the priority from bits [30:28] and the override enable from bit 31. The mask comes from data register bits [9:0] and the valid flag from data bit 11. A later lookup of that ID returns them.
- R5: A load of a new VLAN ID with the data valid flag set, made when no entry is free, sets command bit 4 and leaves the table unchanged. The next accepted command write clears bit 4.
- R6: A load to a VLAN ID that is already valid overwrites that entry in place and takes no new slot. No two valid entries ever hold the same VLAN ID.
- R7: Operation code 3 (purge) invalidates the valid entry whose VLAN ID matches command bits [27:16]. When no entry matches it changes nothing.
- R8: Operation code 4 (remove-port) clears the mask bit selected by command bits [11:8] in every valid entry. A port number of 10 or more changes nothing.
- R9: While bit 3 is set, writes to either register are ignored.
- R10: Read data follows reg_sel. The command register reads back its stored fields, with bit 4 full and bit 3 active. The data register reads mask bits [9:0] and valid bit 11, with all other bits zero. A command write with bit 3 clear stores its fields but starts nothing.
- R11: The lookup is combinational. A hit needs a valid entry with an equal VLAN ID. On a miss, the mask and priority outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| lkp_vid | input | 12 | VLAN ID to look up |
| lkp_hit | output | 1 | A valid entry matches lkp_vid |
| lkp_member | output | 10 | Membership mask of the matching entry |
| lkp_prio | output | 3 | Priority of the matching entry |
| lkp_prio_en | output | 1 | Priority override enable of the matching entry |

## Verification
Several checks run on every cycle. No command stays active longer than the table walk plus one commit cycle. Valid entries never share a VLAN ID. A finished flush leaves no valid entry. The full flag rises only at the end of a load. A command write made during activity leaves the stored fields untouched. Only the bench scenarios can show the values that reach the lookup port: overwrite in place, a purge that misses, remove-port with an out-of-range port, the table filling up, and data writes dropped mid-command.

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine #(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [11:0] lkp_vid,
  output logic        lkp_hit,
  output logic [9:0]  lkp_member,
  output logic [2:0]  lkp_prio,
  output logic        lkp_prio_en
);
  localparam int VID_W  = 12;
  localparam int MEMB_W = 10;
  localparam int PORT_W = 4;
  localparam int PRIO_W = 3;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W  = $clog2(ENTRIES + 3);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  localparam logic [2:0] OP_FLUSH  = 3'd1;
  localparam logic [2:0] OP_LOAD   = 3'd2;
  localparam logic [2:0] OP_PURGE  = 3'd3;
  localparam logic [2:0] OP_RMPORT = 3'd4;

  logic [2:0]        op_q;
  logic              act_q, full_q, commit_q;
  logic [PORT_W-1:0] port_q;
  logic [VID_W-1:0]  vid_q;
  logic [PRIO_W-1:0] prio_q;
  logic              pen_q;
  logic [MEMB_W-1:0] dmem_q;
  logic              dval_q;

  logic [ENTRIES-1:0] t_val;
  logic [VID_W-1:0]   t_vid  [ENTRIES];
  logic [MEMB_W-1:0]  t_mem  [ENTRIES];
  logic [PRIO_W-1:0]  t_prio [ENTRIES];
  logic [ENTRIES-1:0] t_pen;

  logic [IDX_W-1:0] idx_q, hit_idx_q, free_idx_q;
  logic             hit_found_q, free_found_q;

  wire cmd_wr   = reg_we && !reg_sel && !act_q;
  wire data_wr  = reg_we &&  reg_sel && !act_q;
  wire walk_op  = (op_q == OP_FLUSH) || (op_q == OP_LOAD) ||
                  (op_q == OP_PURGE) || (op_q == OP_RMPORT);
  wire idx_last = (idx_q == LAST_IDX);
  wire cur_match = t_val[idx_q] && (t_vid[idx_q] == vid_q);
  wire [MEMB_W-1:0] port_mask =
    (port_q < PORT_W'(MEMB_W)) ? (MEMB_W'(1) << port_q) : '0;

  assign reg_rdata = reg_sel
    ? {20'd0, dval_q, 1'b0, dmem_q}
    : {pen_q, prio_q, vid_q, 4'd0, port_q, 3'd0, full_q, act_q, op_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; act_q <= 1'b0; full_q <= 1'b0; commit_q <= 1'b0;
      port_q <= '0; vid_q <= '0; prio_q <= '0; pen_q <= 1'b0;
      dmem_q <= '0; dval_q <= 1'b0;
    end else begin
      if (data_wr) begin
        dmem_q <= reg_wdata[MEMB_W-1:0];
        dval_q <= reg_wdata[11];
      end
      if (cmd_wr) begin
        op_q   <= reg_wdata[2:0];
        act_q  <= reg_wdata[3];
        port_q <= reg_wdata[11:8];
        vid_q  <= reg_wdata[27:16];
        prio_q <= reg_wdata[30:28];
        pen_q  <= reg_wdata[31];
        full_q <= 1'b0;
      end else if (act_q) begin
        if (commit_q) begin
          act_q    <= 1'b0;
          commit_q <= 1'b0;
          if (!hit_found_q && dval_q && !free_found_q) full_q <= 1'b1;
        end else if (!walk_op) begin
          act_q <= 1'b0;
        end else if (idx_last) begin
          if (op_q == OP_LOAD) commit_q <= 1'b1;
          else act_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; hit_idx_q <= '0; free_idx_q <= '0;
      hit_found_q <= 1'b0; free_found_q <= 1'b0;
    end else if (cmd_wr) begin
      idx_q <= '0;
      hit_found_q <= 1'b0;
      free_found_q <= 1'b0;
    end else if (act_q && walk_op && !commit_q) begin
      idx_q <= idx_last ? '0 : idx_q + 1'b1;
      if (op_q == OP_LOAD) begin
        if (cur_match && !hit_found_q) begin
          hit_found_q <= 1'b1;
          hit_idx_q   <= idx_q;
        end
        if (!t_val[idx_q] && !free_found_q) begin
          free_found_q <= 1'b1;
          free_idx_q   <= idx_q;
        end
      end
    end
  end

  wire              do_store  = act_q && commit_q && (hit_found_q || (dval_q && free_found_q));
  wire [IDX_W-1:0]  store_idx = hit_found_q ? hit_idx_q : free_idx_q;
  wire              walking   = act_q && !commit_q && walk_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_val <= '0;
      t_pen <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        t_vid[i]  <= '0;
        t_mem[i]  <= '0;
        t_prio[i] <= '0;
      end
    end else if (do_store) begin
      t_val[store_idx]  <= dval_q;
      t_vid[store_idx]  <= vid_q;
      t_mem[store_idx]  <= dmem_q;
      t_prio[store_idx] <= prio_q;
      t_pen[store_idx]  <= pen_q;
    end else if (walking) begin
      case (op_q)
        OP_FLUSH:  t_val[idx_q] <= 1'b0;
        OP_PURGE:  if (cur_match) t_val[idx_q] <= 1'b0;
        OP_RMPORT: if (t_val[idx_q]) t_mem[idx_q] <= t_mem[idx_q] & ~port_mask;
        default: ;
      endcase
    end
  end

  always_comb begin
    lkp_hit = 1'b0;
    lkp_member = '0;
    lkp_prio = '0;
    lkp_prio_en = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (t_val[i] && t_vid[i] == lkp_vid) begin
        lkp_hit = 1'b1;
        lkp_member = t_mem[i];
        lkp_prio = t_prio[i];
        lkp_prio_en = t_pen[i];
      end
    end
  end

  logic [CNT_W-1:0] act_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_cnt <= '0;
    else if (act_q) act_cnt <= act_cnt + 1'b1;
    else act_cnt <= '0;
  end

  logic dup_vid;
  always_comb begin
    dup_vid = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (t_val[i] && t_val[j] && t_vid[i] == t_vid[j]) dup_vid = 1'b1;
  end

  AST_ACTIVE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= CNT_W'(ENTRIES + 1)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(act_q) && op_q == OP_FLUSH) |-> (t_val == '0)); // R3
  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> (op_q == OP_LOAD && !act_q)); // R5
  AST_NO_DUP_VID: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_vid); // R6
  AST_IGNORE_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && reg_we && !reg_sel) |=> ($stable(op_q) && $stable(vid_q) && $stable(port_q))); // R9
  AST_IGNORE_BUSY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && reg_we && reg_sel) |=> ($stable(dmem_q) && $stable(dval_q))); // R9
endmodule

// File: tb/vlan_cmd_engine_tb.sv
`timescale 1ns/1ps
module vlan_cmd_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] lkp_vid = '0;
  logic lkp_hit, lkp_prio_en;
  logic [9:0] lkp_member;
  logic [2:0] lkp_prio;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vlan_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lkp_vid(lkp_vid),
    .lkp_hit(lkp_hit), .lkp_member(lkp_member), .lkp_prio(lkp_prio),
    .lkp_prio_en(lkp_prio_en)
  );

  localparam int NV = 7;
  localparam logic [31:0] V_DATA [NV] = '{32'h80F, 32'hBC0, 32'h901, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_CMD  [NV] = '{32'hB005_000A, 32'h0009_000A, 32'h0005_000A,
                                          32'h0000_000C, 32'h0009_000B, 32'h004D_000B, 32'h0000_0009};
  localparam logic [11:0] V_LKP  [NV] = '{12'd5, 12'd9, 12'd5, 12'd5, 12'd9, 12'd5, 12'd5};
  localparam logic        V_HIT  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [9:0]  V_MEM  [NV] = '{10'h00F, 10'h3C0, 10'h101, 10'h100, 10'h000, 10'h100, 10'h000};
  localparam string       V_REQ  [NV] = '{"R4", "R4", "R6", "R8", "R7", "R7", "R3"};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic wait_idle();
    reg_sel = 1'b0;
    for (int k = 0; k < 100; k++) begin
      #0.1;
      if (reg_rdata[3] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [31:0] d, input logic [31:0] data);
    wr(1'b1, data);
    wr(1'b0, d);
    wait_idle();
  endtask

  task automatic look(input string req, input logic [11:0] v, input logic hit, input logic [9:0] mem);
    lkp_vid = v;
    #0.1;
    check(req, {31'd0, lkp_hit}, {31'd0, hit});
    check(req, {22'd0, lkp_member}, {22'd0, mem});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reg_sel = 1'b0; #0.1;
    check("R1 cmd reg", reg_rdata, 32'h0);
    reg_sel = 1'b1; #0.1;
    check("R1 data reg", reg_rdata, 32'h0);
    look("R1 lookup", 12'd0, 1'b0, 10'h0);
    check("R1 prio", {28'd0, lkp_prio_en, lkp_prio}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cmd(V_CMD[i], V_DATA[i]);
      look(V_REQ[i], V_LKP[i], V_HIT[i], V_MEM[i]);
    end

    // R4: priority fields
    cmd(32'hB005_000A, 32'h80F);
    lkp_vid = 12'd5; #0.1;
    check("R4 prio", {28'd0, lkp_prio_en, lkp_prio}, 32'hB);
    // R2: active visible right after start, clears later
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0000_0009);
    #0.1;
    check("R2 active set", {31'd0, reg_rdata[3]}, 32'd1);
    wait_idle();
    check("R2 active clear", {31'd0, reg_rdata[3]}, 32'd0);
    look("R3 flush", 12'd5, 1'b0, 10'h0);

    // R5 / R6: fill the table
    for (int k = 0; k < 16; k++)
      cmd({4'h0, 12'(100 + k), 16'h000A}, 32'h800 | k);
    look("R4 fill", 12'd115, 1'b1, 10'h00F);
    cmd({4'h0, 12'd200, 16'h000A}, 32'h8FF);
    check("R5 full set", {31'd0, reg_rdata[4]}, 32'd1);
    look("R5 table unchanged", 12'd200, 1'b0, 10'h0);
    cmd({4'h0, 12'd100, 16'h000A}, 32'h855);
    check("R5 full clear", {31'd0, reg_rdata[4]}, 32'd0);
    look("R6 overwrite in place", 12'd100, 1'b1, 10'h055);
    look("R6 neighbour kept", 12'd101, 1'b1, 10'h001);

    // R9: writes during a flush are ignored
    wr(1'b0, 32'h0000_0009);
    wr(1'b0, {4'h0, 12'd300, 16'h000A});
    wr(1'b1, 32'h0000_0ABC);
    wait_idle();
    check("R9 cmd kept", reg_rdata, 32'h0000_0001);
    reg_sel = 1'b1; #0.1;
    check("R9 data kept", reg_rdata, 32'h0000_0855);
    look("R9 no load", 12'd300, 1'b0, 10'h0);

    // R8: port out of range, then in range
    cmd({4'h0, 12'd7, 16'h000A}, 32'hBFF);
    cmd(32'h0000_0C0C, 32'h0);
    look("R8 port 12 no effect", 12'd7, 1'b1, 10'h3FF);
    cmd(32'h0000_090C, 32'h0);
    look("R8 port 9 removed", 12'd7, 1'b1, 10'h1FF);

    // R2: unknown op changes nothing
    cmd(32'h0007_000D, 32'h0);
    check("R2 unknown op idle", {31'd0, reg_rdata[3]}, 32'd0);
    look("R2 unknown op", 12'd7, 1'b1, 10'h1FF);

    // R10: readback, and a command without start
    wr(1'b1, 32'hFFFF_FFFF);
    reg_sel = 1'b1; #0.1;
    check("R10 data read", reg_rdata, 32'h0000_0BFF);
    wr(1'b0, 32'hB005_0302);
    #0.1;
    check("R10 cmd read", reg_rdata, 32'hB005_0302);
    look("R10 no start", 12'd5, 1'b0, 10'h0);
    look("R11 hit", 12'd7, 1'b1, 10'h1FF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule